// File: doc/BRIEF.md
# Prebyte Instruction Framer

This block sits between an instruction fetch stream and the decoder of an 8-bit CPU whose opcode space is split into four pages of 256 opcodes each. It accepts one byte per handshake, recognises an optional page-select byte, captures the opcode and then as many operand bytes as the opcode needs. When an instruction is complete, it presents the whole instruction in one cycle: the page, the opcode, the packed operands, the operand count, the total length, and an illegal flag.

Instructions have no alignment constraint and follow one another directly in the stream, so the framer restarts after every completed instruction. The operand count of each opcode comes from a small built-in per-page table that covers a chosen subset of opcodes. A flush input drops any partly assembled instruction, for example when a taken branch redirects fetch.

Top module: `prebyte_framer`

## Requirements
- R1: After reset `instr_valid_o` is 0, `byte_ready_o` is 1, and every frame field output is 0.
- R2: A byte that arrives first and is not a page-select value is taken as an opcode of page 0. `page_o` is 0 and `prebyte_o` is 0.
- R3: A first byte of 0x18, 0x1A or 0xCD selects page 1, 2 or 3 respectively, and `prebyte_o` is 1. The byte after it is always the opcode of that page, even if it has a page-select value.
- R4: The operand count is taken from this table, and every other opcode has none. Page 0: 0x01, 0x08 and 0x3F take 0; 0x20, 0x86, 0x96 and 0xA6 take 1; 0xB6 and 0xCE take 2; 0x12 takes 3. Page 1: 0x08 takes 0; 0xA6 takes 1; 0xCE takes 2; 0x1E takes 3. Page 2: 0xA3 takes 1; 0x83 and 0xB3 take 2. Page 3: 0xA3 and 0xEE take 1.
- R5: Operands are reported in arrival order. Operand k (k=0 first) sits in `opnd_o[8k+7:8k]`, and unused slots read 0. A 16-bit operand therefore has its high byte in slot 0.
- R6: `len_o` equals `prebyte_o` + 1 + `opnd_cnt_o`, which always lies in the range 1 to 5.
- R7: An opcode that is not in the table gives `illegal_o` = 1 with zero operands. Its frame completes on the opcode byte.
- R8: `instr_valid_o` is high for exactly one cycle. That cycle directly follows the clock edge that accepted the last byte of the instruction. All frame outputs hold their values until the next pulse.
- R9: `byte_ready_o` is 0 in the cycle `instr_valid_o` is high, and it is 1 in every other cycle that has no flush.
- R10: While `flush_i` is 1, `byte_ready_o` is 0 and no byte is consumed. A partly assembled instruction is dropped, and the next accepted byte starts a new instruction on page 0.
- R11: Instructions follow each other directly in the stream with no alignment or gap requirement. Each instruction produces exactly one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Synchronous discard of a partial instruction |
| byte_i | input | 8 | Fetched byte |
| byte_valid_i | input | 1 | `byte_i` holds a byte |
| byte_ready_o | output | 1 | Framer takes `byte_i` at this edge |
| instr_valid_o | output | 1 | One-cycle pulse: the frame outputs hold a complete instruction |
| prebyte_o | output | 1 | Instruction began with a page-select byte |
| page_o | output | 2 | Opcode page 0 to 3 |
| opcode_o | output | 8 | Opcode byte |
| opnd_o | output | 24 | Operand bytes, slot k at bits 8k+7:8k |
| opnd_cnt_o | output | 2 | Number of operand bytes |
| len_o | output | 3 | Total instruction length in bytes |
| illegal_o | output | 1 | Opcode absent from the table |

## Verification
The bench sweeps every opcode of every page through the framer and predicts each frame from its own copy of the table. This exposes a wrong entry, an operand slot written out of order, or a length that leaves out the page-select byte. Page-select values that are sent as opcodes after a page-select byte are part of the sweep. A design that re-entered page selection at that point would report a later page or would hang waiting for an opcode. Flushes are placed after a page-select byte, in the middle of the operands, and together with a valid byte. A framer that kept stale page state or swallowed the byte during a flush would produce a wrong or extra frame. A back-to-back stream checks that the stall cycle after each pulse loses no byte.

// File: rtl/ifr_pkg.sv
package ifr_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned PAGE_W    = 2;
  localparam int unsigned NOPND_MAX = 3;
  localparam int unsigned CNT_W     = $clog2(NOPND_MAX + 1);
  localparam int unsigned LEN_W     = $clog2(NOPND_MAX + 3);

  typedef enum logic [1:0] {
    ST_HEAD,
    ST_OPC,
    ST_OPND
  } seq_st_e;

  typedef struct packed {
    logic             legal;
    logic [CNT_W-1:0] nops;
  } opc_info_t;

  function automatic opc_info_t opc_lookup(input logic [PAGE_W-1:0] pg,
                                           input logic [BYTE_W-1:0] op);
    opc_info_t r;
    r.legal = 1'b1;
    r.nops  = '0;
    case (pg)
      2'd0: case (op)
        8'h01, 8'h08, 8'h3F:        r.nops = CNT_W'(0);
        8'h20, 8'h86, 8'h96, 8'hA6: r.nops = CNT_W'(1);
        8'hB6, 8'hCE:               r.nops = CNT_W'(2);
        8'h12:                      r.nops = CNT_W'(3);
        default:                    r.legal = 1'b0;
      endcase
      2'd1: case (op)
        8'h08:   r.nops = CNT_W'(0);
        8'hA6:   r.nops = CNT_W'(1);
        8'hCE:   r.nops = CNT_W'(2);
        8'h1E:   r.nops = CNT_W'(3);
        default: r.legal = 1'b0;
      endcase
      2'd2: case (op)
        8'hA3:        r.nops = CNT_W'(1);
        8'h83, 8'hB3: r.nops = CNT_W'(2);
        default:      r.legal = 1'b0;
      endcase
      default: case (op)
        8'hA3, 8'hEE: r.nops = CNT_W'(1);
        default:      r.legal = 1'b0;
      endcase
    endcase
    return r;
  endfunction
endpackage

// File: rtl/ifr_decode.sv
module ifr_decode
  import ifr_pkg::*;
#(
  parameter logic [BYTE_W-1:0] PRE_P1 = 8'h18,
  parameter logic [BYTE_W-1:0] PRE_P2 = 8'h1A,
  parameter logic [BYTE_W-1:0] PRE_P3 = 8'hCD
) (
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [PAGE_W-1:0] sel_page_i,
  output logic              is_pre_o,
  output logic [PAGE_W-1:0] pre_page_o,
  output opc_info_t         info_o
);
  localparam int unsigned NPAGE = 1 << PAGE_W;
  localparam logic [(NPAGE-1)*BYTE_W-1:0] PRE_TBL = {PRE_P3, PRE_P2, PRE_P1};

  logic [NPAGE-1:0] hit;
  assign hit[0] = 1'b0;

  for (genvar g = 1; g < NPAGE; g++) begin : g_pre
    assign hit[g] = (byte_i == PRE_TBL[(g-1)*BYTE_W +: BYTE_W]);
  end

  always_comb begin
    pre_page_o = '0;
    for (int i = 1; i < NPAGE; i++) begin
      if (hit[i]) pre_page_o = PAGE_W'(i);
    end
  end

  assign is_pre_o = |hit;
  assign info_o   = opc_lookup(sel_page_i, byte_i);
endmodule

// File: rtl/ifr_seq.sv
module ifr_seq
  import ifr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              fire_i,
  input  logic              is_pre_i,
  input  logic [PAGE_W-1:0] pre_page_i,
  input  opc_info_t         info_i,
  output logic [PAGE_W-1:0] sel_page_o,
  output logic              load_opc_o,
  output logic              load_opnd_o,
  output logic [CNT_W-1:0]  idx_o,
  output logic              done_o,
  output logic [PAGE_W-1:0] fr_page_o,
  output logic              fr_pre_o,
  output logic [CNT_W-1:0]  fr_nops_o,
  output logic              fr_illegal_o
);
  seq_st_e           st_q;
  logic [PAGE_W-1:0] page_q;
  logic [CNT_W-1:0]  nops_q, idx_q;
  logic              pre_q;
  logic              take_pre, last_opnd;

  always_comb begin
    sel_page_o   = (st_q == ST_OPC) ? page_q : '0;
    take_pre     = fire_i && (st_q == ST_HEAD) && is_pre_i;
    load_opc_o   = fire_i && ((st_q == ST_OPC) || ((st_q == ST_HEAD) && !is_pre_i));
    load_opnd_o  = fire_i && (st_q == ST_OPND);
    last_opnd    = (idx_q == nops_q - CNT_W'(1));
    done_o       = (load_opc_o && (info_i.nops == '0)) || (load_opnd_o && last_opnd);
    fr_page_o    = load_opc_o ? sel_page_o : page_q;
    fr_pre_o     = load_opc_o ? (st_q == ST_OPC) : pre_q;
    fr_nops_o    = load_opc_o ? info_i.nops : nops_q;
    fr_illegal_o = load_opc_o && !info_i.legal;
  end

  assign idx_o = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_HEAD;
      page_q <= '0;
      nops_q <= '0;
      idx_q  <= '0;
      pre_q  <= 1'b0;
    end else if (flush_i) begin
      st_q   <= ST_HEAD;
      page_q <= '0;
      idx_q  <= '0;
      pre_q  <= 1'b0;
    end else begin
      if (take_pre) begin
        st_q   <= ST_OPC;
        page_q <= pre_page_i;
      end
      if (load_opc_o) begin
        page_q <= sel_page_o;
        pre_q  <= (st_q == ST_OPC);
        nops_q <= info_i.nops;
        idx_q  <= '0;
        st_q   <= (info_i.nops == '0) ? ST_HEAD : ST_OPND;
      end
      if (load_opnd_o) begin
        idx_q <= idx_q + CNT_W'(1);
        if (last_opnd) st_q <= ST_HEAD;
      end
    end
  end
endmodule

// File: rtl/ifr_frame_reg.sv
module ifr_frame_reg
  import ifr_pkg::*;
(
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [BYTE_W-1:0]           byte_i,
  input  logic                        load_opc_i,
  input  logic                        load_opnd_i,
  input  logic [CNT_W-1:0]            idx_i,
  input  logic                        done_i,
  input  logic [PAGE_W-1:0]           fr_page_i,
  input  logic                        fr_pre_i,
  input  logic [CNT_W-1:0]            fr_nops_i,
  input  logic                        fr_illegal_i,
  output logic                        valid_o,
  output logic                        prebyte_o,
  output logic [PAGE_W-1:0]           page_o,
  output logic [BYTE_W-1:0]           opcode_o,
  output logic [NOPND_MAX*BYTE_W-1:0] opnd_o,
  output logic [CNT_W-1:0]            cnt_o,
  output logic [LEN_W-1:0]            len_o,
  output logic                        illegal_o
);
  logic [BYTE_W-1:0]           op_q;
  logic [NOPND_MAX*BYTE_W-1:0] slot_bus;

  for (genvar k = 0; k < NOPND_MAX; k++) begin : g_slot
    logic [BYTE_W-1:0] q, d;
    always_comb begin
      if (load_opnd_i && (idx_i == CNT_W'(k))) d = byte_i;
      else if (load_opc_i)                     d = '0;
      else                                     d = q;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else         q <= d;
    end
    assign slot_bus[k*BYTE_W +: BYTE_W] = d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) op_q <= '0;
    else if (load_opc_i) op_q <= byte_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      prebyte_o <= 1'b0;
      page_o    <= '0;
      opcode_o  <= '0;
      opnd_o    <= '0;
      cnt_o     <= '0;
      len_o     <= '0;
      illegal_o <= 1'b0;
    end else begin
      valid_o <= done_i;
      if (done_i) begin
        prebyte_o <= fr_pre_i;
        page_o    <= fr_page_i;
        opcode_o  <= load_opc_i ? byte_i : op_q;
        opnd_o    <= slot_bus;
        cnt_o     <= fr_nops_i;
        len_o     <= LEN_W'(fr_pre_i) + LEN_W'(1) + LEN_W'(fr_nops_i);
        illegal_o <= fr_illegal_i;
      end
    end
  end
endmodule

// File: rtl/prebyte_framer.sv
module prebyte_framer
  import ifr_pkg::*;
#(
  parameter logic [7:0] PRE_P1 = 8'h18,
  parameter logic [7:0] PRE_P2 = 8'h1A,
  parameter logic [7:0] PRE_P3 = 8'hCD
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        flush_i,
  input  logic [7:0]  byte_i,
  input  logic        byte_valid_i,
  output logic        byte_ready_o,
  output logic        instr_valid_o,
  output logic        prebyte_o,
  output logic [1:0]  page_o,
  output logic [7:0]  opcode_o,
  output logic [23:0] opnd_o,
  output logic [1:0]  opnd_cnt_o,
  output logic [2:0]  len_o,
  output logic        illegal_o
);
  logic              fire, is_pre, load_opc, load_opnd, done;
  logic              fr_pre, fr_illegal;
  logic [PAGE_W-1:0] pre_page, sel_page, fr_page;
  logic [CNT_W-1:0]  idx, fr_nops;
  opc_info_t         info;

  // one stall cycle per frame keeps the output stage single-entry
  assign byte_ready_o = !instr_valid_o && !flush_i;
  assign fire         = byte_valid_i && byte_ready_o;

  ifr_decode #(
    .PRE_P1(PRE_P1), .PRE_P2(PRE_P2), .PRE_P3(PRE_P3)
  ) i_decode (
    .byte_i    (byte_i),
    .sel_page_i(sel_page),
    .is_pre_o  (is_pre),
    .pre_page_o(pre_page),
    .info_o    (info)
  );

  ifr_seq i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush_i),
    .fire_i      (fire),
    .is_pre_i    (is_pre),
    .pre_page_i  (pre_page),
    .info_i      (info),
    .sel_page_o  (sel_page),
    .load_opc_o  (load_opc),
    .load_opnd_o (load_opnd),
    .idx_o       (idx),
    .done_o      (done),
    .fr_page_o   (fr_page),
    .fr_pre_o    (fr_pre),
    .fr_nops_o   (fr_nops),
    .fr_illegal_o(fr_illegal)
  );

  ifr_frame_reg i_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .byte_i      (byte_i),
    .load_opc_i  (load_opc),
    .load_opnd_i (load_opnd),
    .idx_i       (idx),
    .done_i      (done),
    .fr_page_i   (fr_page),
    .fr_pre_i    (fr_pre),
    .fr_nops_i   (fr_nops),
    .fr_illegal_i(fr_illegal),
    .valid_o     (instr_valid_o),
    .prebyte_o   (prebyte_o),
    .page_o      (page_o),
    .opcode_o    (opcode_o),
    .opnd_o      (opnd_o),
    .cnt_o       (opnd_cnt_o),
    .len_o       (len_o),
    .illegal_o   (illegal_o)
  );
endmodule

// File: rtl/ifr_checker.sv
module ifr_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        flush_i,
  input logic        byte_ready_o,
  input logic        instr_valid_o,
  input logic        prebyte_o,
  input logic [1:0]  page_o,
  input logic [7:0]  opcode_o,
  input logic [23:0] opnd_o,
  input logic [1:0]  opnd_cnt_o,
  input logic [2:0]  len_o,
  input logic        illegal_o
);
  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_o |=> !instr_valid_o); // R8
  AST_FIELDS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !instr_valid_o |-> ($stable(opcode_o) && $stable(opnd_o) && $stable(len_o) && $stable(page_o))); // R8
  AST_STALL_ON_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_o |-> !byte_ready_o); // R9
  AST_STALL_ON_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> !byte_ready_o); // R10
  AST_LEN_BOUNDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_o |-> (len_o >= 3'd1 && len_o <= 3'd5)); // R6
  AST_LEN_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_o |-> (len_o == 3'(prebyte_o) + 3'd1 + 3'(opnd_cnt_o))); // R6
  AST_PAGE_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_o |-> ((page_o != 2'd0) == prebyte_o)); // R3
  AST_ILLEGAL_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_o && illegal_o) |-> (opnd_cnt_o == 2'd0 && opnd_o == 24'd0)); // R7
endmodule

bind prebyte_framer ifr_checker i_ifr_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .flush_i      (flush_i),
  .byte_ready_o (byte_ready_o),
  .instr_valid_o(instr_valid_o),
  .prebyte_o    (prebyte_o),
  .page_o       (page_o),
  .opcode_o     (opcode_o),
  .opnd_o       (opnd_o),
  .opnd_cnt_o   (opnd_cnt_o),
  .len_o        (len_o),
  .illegal_o    (illegal_o)
);

// File: tb/test_prebyte_framer.sv
module test_prebyte_framer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic [7:0]  byte_in = 8'h00;
  logic        byte_valid = 1'b0;
  logic        byte_ready_o, instr_valid_o, prebyte_o, illegal_o;
  logic [1:0]  page_o, opnd_cnt_o;
  logic [7:0]  opcode_o;
  logic [23:0] opnd_o;
  logic [2:0]  len_o;

  int n_cmp = 0;
  int n_bad = 0;
  int pulse_cnt = 0;
  logic [7:0]  cap_op [8];
  logic [23:0] cap_opnd [8];
  logic [1:0]  cap_page [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  prebyte_framer i_prebyte_framer (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .byte_i(byte_in),
    .byte_valid_i(byte_valid), .byte_ready_o(byte_ready_o),
    .instr_valid_o(instr_valid_o), .prebyte_o(prebyte_o), .page_o(page_o),
    .opcode_o(opcode_o), .opnd_o(opnd_o), .opnd_cnt_o(opnd_cnt_o),
    .len_o(len_o), .illegal_o(illegal_o)
  );

  always @(negedge clk) begin
    if (rst_n && instr_valid_o) begin
      cap_op[pulse_cnt % 8]   = opcode_o;
      cap_opnd[pulse_cnt % 8] = opnd_o;
      cap_page[pulse_cnt % 8] = page_o;
      pulse_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // operand count from the requirement table; -1 marks an absent opcode
  function automatic int tb_ops(input int pg, input int op);
    if (pg == 0) begin
      if (op == 'h01 || op == 'h08 || op == 'h3F) return 0;
      if (op == 'h20 || op == 'h86 || op == 'h96 || op == 'hA6) return 1;
      if (op == 'hB6 || op == 'hCE) return 2;
      if (op == 'h12) return 3;
    end else if (pg == 1) begin
      if (op == 'h08) return 0;
      if (op == 'hA6) return 1;
      if (op == 'hCE) return 2;
      if (op == 'h1E) return 3;
    end else if (pg == 2) begin
      if (op == 'hA3) return 1;
      if (op == 'h83 || op == 'hB3) return 2;
    end else begin
      if (op == 'hA3 || op == 'hEE) return 1;
    end
    return -1;
  endfunction

  function automatic logic [7:0] pre_of(input int pg);
    return (pg == 1) ? 8'h18 : (pg == 2) ? 8'h1A : 8'hCD;
  endfunction

  task automatic put(input logic [7:0] b);
    @(negedge clk);
    byte_valid = 1'b1;
    byte_in    = b;
    while (!byte_ready_o) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic frame(input int pg, input int op);
    int          ops;
    int          n;
    logic [23:0] exp_opnd;
    logic [7:0]  ob;
    string       preq;
    ops = tb_ops(pg, op);
    n = (ops < 0) ? 0 : ops;
    exp_opnd = '0;
    preq = (pg == 0) ? "R2" : "R3";
    if (pg != 0) put(pre_of(pg));
    put(8'(op));
    for (int k = 0; k < n; k++) begin
      ob = 8'((op * 7 + k * 37 + pg) ^ 'hA5);
      exp_opnd[k*8 +: 8] = ob;
      put(ob);
    end
    @(negedge clk);
    byte_valid = 1'b0;
    chk(instr_valid_o == 1'b1, "R8", "pulse after last byte", 32'(instr_valid_o), 32'd1);
    chk(page_o == 2'(pg), preq, "page", 32'(page_o), 32'(pg));
    chk(prebyte_o == (pg != 0), preq, "prebyte flag", 32'(prebyte_o), 32'(pg != 0));
    chk(opcode_o == 8'(op), preq, "opcode", 32'(opcode_o), 32'(op));
    chk(opnd_cnt_o == 2'(n), "R4", "operand count", 32'(opnd_cnt_o), 32'(n));
    chk(opnd_o == exp_opnd, "R5", "operands", 32'(opnd_o), 32'(exp_opnd));
    chk(len_o == 3'((pg != 0) + 1 + n), "R6", "length", 32'(len_o), 32'((pg != 0) + 1 + n));
    chk(illegal_o == (ops < 0), "R7", "illegal", 32'(illegal_o), 32'(ops < 0));
    chk(byte_ready_o == 1'b0, "R9", "ready during pulse", 32'(byte_ready_o), 32'd0);
    @(negedge clk);
    chk(instr_valid_o == 1'b0, "R8", "pulse width", 32'(instr_valid_o), 32'd0);
    chk(opcode_o == 8'(op) && opnd_o == exp_opnd, "R8", "hold after pulse", 32'(opcode_o), 32'(op));
    chk(byte_ready_o == 1'b1, "R9", "ready after pulse", 32'(byte_ready_o), 32'd1);
  endtask

  task automatic do_flush(input bit with_byte, input logic [7:0] b);
    @(negedge clk);
    flush      = 1'b1;
    byte_valid = with_byte;
    byte_in    = b;
    #1;
    chk(byte_ready_o == 1'b0, "R10", "ready during flush", 32'(byte_ready_o), 32'd0);
    @(negedge clk);
    flush      = 1'b0;
    byte_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    int p0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(instr_valid_o == 0 && byte_ready_o == 1, "R1", "reset handshake",
        32'({instr_valid_o, byte_ready_o}), 32'b01);
    chk(opcode_o == 0 && opnd_o == 0 && len_o == 0 && page_o == 0 && illegal_o == 0 && prebyte_o == 0,
        "R1", "reset fields", 32'(opcode_o), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R5 R6 R7 sweep over all pages and opcodes
    for (int pg = 0; pg < 4; pg++) begin
      for (int op = 0; op < 256; op++) begin
        if (pg == 0 && (op == 'h18 || op == 'h1A || op == 'hCD)) continue;
        frame(pg, op);
      end
    end

    // R10 flush after prebyte, then page 0 opcode
    put(8'h18);
    do_flush(1'b0, 8'h00);
    frame(0, 'h86);
    // R10 flush mid-operands
    put(8'hB6);
    put(8'h12);
    do_flush(1'b0, 8'h00);
    frame(0, 'h01);
    // R10 byte offered during flush is not consumed
    p0 = pulse_cnt;
    do_flush(1'b1, 8'h01);
    @(negedge clk);
    chk(pulse_cnt == p0 && instr_valid_o == 0, "R10", "no frame from flushed byte",
        32'(pulse_cnt - p0), 32'd0);

    // R11 back-to-back stream
    p0 = pulse_cnt;
    put(8'h86); put(8'h11);
    put(8'h18); put(8'hCE); put(8'h12); put(8'h34);
    put(8'h3F);
    @(negedge clk);
    byte_valid = 1'b0;
    @(negedge clk);
    chk(pulse_cnt - p0 == 3, "R11", "pulse count", 32'(pulse_cnt - p0), 32'd3);
    chk(cap_op[p0 % 8] == 8'h86 && cap_opnd[p0 % 8] == 24'h000011, "R11", "first frame",
        32'(cap_opnd[p0 % 8]), 32'h11);
    chk(cap_page[(p0+1) % 8] == 2'd1 && cap_op[(p0+1) % 8] == 8'hCE, "R11", "second frame page/opcode",
        32'(cap_op[(p0+1) % 8]), 32'hCE);
    chk(cap_opnd[(p0+1) % 8] == 24'h003412, "R5", "16-bit high byte in slot 0",
        32'(cap_opnd[(p0+1) % 8]), 32'h3412);
    chk(cap_op[(p0+2) % 8] == 8'h3F && cap_page[(p0+2) % 8] == 2'd0, "R11", "third frame",
        32'(cap_op[(p0+2) % 8]), 32'h3F);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule